// File: doc/BRIEF.md
# Ping-Pong Receive Buffer Controller

This block is the receive front end of a small Ethernet MAC. Received bytes arrive one per cycle on a stream with a valid strobe and an end-of-frame marker. Each frame is stored into one of two memory-mapped word buffers, which act as a ping and a pong pair. When the frame ends, the block raises a per-buffer completion flag. Software reads the frame over a simple word bus. It then hands the buffer back by writing its completion flag to zero.

Frames are placed in strict alternation, ping first and then pong, so that a reader that polls in the same order always finds the oldest frame first. A buffer whose completion flag is still set is never overwritten. If the buffer next in order is occupied when a frame begins, the whole frame is discarded and the order is kept. The pong buffer is a build option. Without it, every frame targets the ping buffer.

Top module: `rx_pingpong_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both status words read 0, nothing is stored as pending, the next frame targets ping, and `rx_irq` is low.
- R2: Received bytes are packed into 32-bit words, least significant byte first. Byte k of a frame sits in word k/4, lane k%4, of the chosen buffer. The ping words are at bus byte address 0x1000+4w and the pong words at 0x1800+4w. The last word of a frame that is cut short by the end marker has its unused upper lanes written as 0.
- R3: Accepting the final byte of a frame sets bit 0 (done) of that buffer's status word: 0x17FC for ping, 0x1FFC for pong. The bit stays set until software clears it.
- R4: With the pong buffer built in, successive accepted frames go to ping, then pong, then ping, and so on. The order advances only when an accepted frame completes.
- R5: If the buffer next in order has done set when a frame's first byte arrives, the whole frame is dropped. Neither buffer's contents or status change, and the order does not advance. After that buffer is released, the next frame lands in it.
- R6: A bus write to a status word sets bit 3 (receive interrupt enable) from bit 3 of the data. It clears done when bit 0 of the data is 0. Writing 1 to bit 0 never sets done.
- R7: `rx_irq` pulses high for one cycle, in the cycle after the last byte is accepted, when the completed buffer's enable (bit 3) and `glb_irq_en` are both 1. In every other case it stays low.
- R8: Bytes beyond BUF_WORDS*4 in a frame are not stored. The frame still completes and sets done. Word indexes at or beyond BUF_WORDS read as 0.
- R9: Without the pong buffer, every accepted frame goes to ping, and the whole pong region, status word included, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | This byte ends the frame |
| glb_irq_en | input | 1 | Global interrupt enable from the MAC |
| bus_addr | input | 13 | Bus byte address (word aligned) |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_wdata | input | 32 | Bus write data |
| bus_rd_en | input | 1 | Bus read strobe; data appears one cycle later |
| bus_rdata | output | 32 | Registered bus read data |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |

## Verification
The assertions assume that `rx_valid` is only raised with a byte that belongs to a well-formed stream: every frame ends with a byte that carries `rx_last`, and frames do not overlap. They also assume that software writes a status word only to release a buffer or to change its enable. The bench drives every frame as one contiguous burst ending in the marker. It touches status words only between frames, so a release write never coincides with a frame completing.

// File: rtl/rxpp_pkg.sv
// Shared constants and types for the ping-pong receive buffer controller.
// Assumes each buffer region holds at most 511 words below its status word.
package rxpp_pkg;
    localparam int IDX_W    = 9;
    localparam int DONE_BIT = 0;
    localparam int IE_BIT   = 3;

    typedef logic [IDX_W-1:0] widx_t;

    // One word write produced by the byte packer
    typedef struct packed {
        logic        en;
        widx_t       idx;
        logic [31:0] data;
    } word_wr_t;
endpackage

// File: rtl/rxpp_packer.sv
// Byte-to-word packer. Gathers accepted bytes little-endian into 32-bit
// words and emits a write when a word fills or the frame ends. It stops
// writing once the word index reaches BUF_WORDS, which truncates the frame.
// Assumes `first` marks the first accepted byte of each frame.
module rxpp_packer
    import rxpp_pkg::*;
#(
    parameter int BUF_WORDS = 511
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_en,
    input  logic       first,
    input  logic       last,
    input  logic [7:0] byte_i,
    output word_wr_t   wr
);
    localparam widx_t LIMIT = widx_t'(BUF_WORDS);

    logic [1:0]  lane_q, lane;
    widx_t       idx_q, idx;
    logic [31:0] acc_q, base, merged;
    logic        full, close;

    // Merge the incoming byte into the current word and decide whether to write it
    always_comb begin
        lane   = first ? 2'd0 : lane_q;
        idx    = first ? '0 : idx_q;
        base   = first ? '0 : acc_q;
        merged = base | ({24'b0, byte_i} << {lane, 3'b000});
        full   = (idx >= LIMIT);
        close  = (lane == 2'd3) || last;
        wr.en   = byte_en && close && !full;
        wr.idx  = idx;
        wr.data = merged;
    end

    // Track lane, word index and the partial word between bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
            idx_q  <= '0;
            acc_q  <= '0;
        end else if (byte_en) begin
            if (close) begin
                acc_q  <= '0;
                lane_q <= '0;
                idx_q  <= full ? idx : idx + widx_t'(1);
            end else begin
                acc_q  <= merged;
                lane_q <= lane + 2'd1;
                idx_q  <= idx;
            end
        end
    end
endmodule

// File: rtl/rxpp_frame_ctl.sv
// Frame sequencer. At the first byte of a frame it picks the buffer next in
// order. If that buffer is still pending, it drops the frame up to its end
// marker. It advances the order only when an accepted frame completes.
// Assumes rx_last closes every frame.
module rxpp_frame_ctl #(
    parameter int NUM_BUF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic       rx_last,
    input  logic [1:0] done_vec,
    output logic       byte_en,
    output logic       first,
    output logic       frame_end,
    output logic       tgt,
    output logic       ptr
);
    logic in_frame_q, drop_q, tgt_q, ptr_q;
    logic start, accept;

    // Decide, byte by byte, whether the byte is stored and where it goes
    always_comb begin
        start     = rx_valid && !in_frame_q;
        accept    = start ? !done_vec[ptr_q] : !drop_q;
        byte_en   = rx_valid && accept;
        first     = start;
        frame_end = byte_en && rx_last;
        tgt       = start ? ptr_q : tgt_q;
        ptr       = ptr_q;
    end

    // Hold the frame state: inside a frame, dropping it, and its target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            drop_q     <= 1'b0;
            tgt_q      <= 1'b0;
        end else if (rx_valid) begin
            if (rx_last) begin
                in_frame_q <= 1'b0;
            end else if (start) begin
                in_frame_q <= 1'b1;
                drop_q     <= done_vec[ptr_q];
                tgt_q      <= ptr_q;
            end
        end
    end

    generate
        if (NUM_BUF == 2) begin : g_alt
            // Step the alternation pointer after each accepted frame
            always_ff @(posedge clk) begin
                if (!rst_n)         ptr_q <= 1'b0;
                else if (frame_end) ptr_q <= ~ptr_q;
            end
        end else begin : g_fixed
            assign ptr_q = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/rxpp_status.sv
// Per-buffer status: a done flag set by hardware and cleared by software,
// an interrupt enable, and the shared receive interrupt pulse. A hardware
// set wins over a software write in the same cycle.
module rxpp_status #(
    parameter int NUM_BUF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_end,
    input  logic       tgt,
    input  logic [1:0] stat_wr,
    input  logic       wr_done_bit,
    input  logic       wr_ie_bit,
    input  logic       glb_irq_en,
    output logic [1:0] done_vec,
    output logic [1:0] ie_vec,
    output logic       irq
);
    logic [1:0] set_vec;

    generate
        for (genvar b = 0; b < 2; b++) begin : g_buf
            if (b < NUM_BUF) begin : g_on
                logic done_q, ie_q;
                assign set_vec[b] = frame_end && (tgt == 1'(b));
                // Done: set on completion, cleared only by writing 0
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        done_q <= 1'b0;
                        ie_q   <= 1'b0;
                    end else begin
                        if (set_vec[b])      done_q <= 1'b1;
                        else if (stat_wr[b]) done_q <= done_q && wr_done_bit;
                        if (stat_wr[b])      ie_q   <= wr_ie_bit;
                    end
                end
                assign done_vec[b] = done_q;
                assign ie_vec[b]   = ie_q;
            end else begin : g_off
                assign set_vec[b]  = 1'b0;
                assign done_vec[b] = 1'b0;
                assign ie_vec[b]   = 1'b0;
            end
        end
    endgenerate

    // Pulse the interrupt when an enabled buffer completes
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= glb_irq_en && |(set_vec & ie_vec);
    end
endmodule

// File: rtl/rxpp_buf_ram.sv
// Word storage for one receive buffer: a single write port from the packer
// and a combinational read port that returns 0 past BUF_WORDS.
// Assumes the writer never presents an index at or past BUF_WORDS.
module rxpp_buf_ram
    import rxpp_pkg::*;
#(
    parameter int BUF_WORDS = 511
) (
    input  logic        clk,
    input  word_wr_t    wr,
    input  widx_t       rd_idx,
    output logic [31:0] rd_word
);
    localparam int    AW    = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;
    localparam widx_t LIMIT = widx_t'(BUF_WORDS);

    logic [31:0] mem [BUF_WORDS];

    // Store packed words
    always_ff @(posedge clk) begin
        if (wr.en) mem[wr.idx[AW-1:0]] <= wr.data;
    end

    // Read a word, or 0 outside the storage
    always_comb begin
        rd_word = (rd_idx < LIMIT) ? mem[rd_idx[AW-1:0]] : 32'd0;
    end
endmodule

// File: rtl/rx_pingpong_ctrl.sv
// Ping-pong receive buffer controller top. It decodes the bus window
// 0x1000-0x1FFF: bit 11 selects the buffer and word 0x1FF of each half is
// its status. It wires the sequencer, packer, status and buffer storage.
// Assumes bus addresses are word aligned.
module rx_pingpong_ctrl
    import rxpp_pkg::*;
#(
    parameter bit DUAL_BUF  = 1'b1,
    parameter int BUF_WORDS = 511
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    input  logic        glb_irq_en,
    input  logic [12:0] bus_addr,
    input  logic        bus_wr_en,
    input  logic [31:0] bus_wdata,
    input  logic        bus_rd_en,
    output logic [31:0] bus_rdata,
    output logic        rx_irq
);
    localparam int    NUM_BUF  = DUAL_BUF ? 2 : 1;
    localparam widx_t STAT_IDX = '1;

    logic        byte_en, first, frame_end, tgt, ptr;
    word_wr_t    pk_wr;
    logic [1:0]  done_vec, ie_vec, ram_we, stat_wr;
    logic [31:0] ram_rd [2];
    logic        in_rx, bsel, is_stat, bsel_ok;
    widx_t       aidx;
    logic [31:0] rd_next;

    // Decode the bus address into region, buffer, word and status hit
    always_comb begin
        in_rx   = bus_addr[12];
        bsel    = bus_addr[11];
        aidx    = bus_addr[10:2];
        is_stat = (aidx == STAT_IDX);
        bsel_ok = (NUM_BUF == 2) || !bsel;
    end

    rxpp_frame_ctl #(.NUM_BUF(NUM_BUF)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_last  (rx_last),
        .done_vec (done_vec),
        .byte_en  (byte_en),
        .first    (first),
        .frame_end(frame_end),
        .tgt      (tgt),
        .ptr      (ptr)
    );

    rxpp_packer #(.BUF_WORDS(BUF_WORDS)) u_packer (
        .clk    (clk),
        .rst_n  (rst_n),
        .byte_en(byte_en),
        .first  (first),
        .last   (rx_last),
        .byte_i (rx_data),
        .wr     (pk_wr)
    );

    rxpp_status #(.NUM_BUF(NUM_BUF)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_end  (frame_end),
        .tgt        (tgt),
        .stat_wr    (stat_wr),
        .wr_done_bit(bus_wdata[DONE_BIT]),
        .wr_ie_bit  (bus_wdata[IE_BIT]),
        .glb_irq_en (glb_irq_en),
        .done_vec   (done_vec),
        .ie_vec     (ie_vec),
        .irq        (rx_irq)
    );

    generate
        for (genvar b = 0; b < 2; b++) begin : g_mem
            assign stat_wr[b] = bus_wr_en && in_rx && is_stat && bsel_ok && (bsel == 1'(b));
            if (b < NUM_BUF) begin : g_on
                word_wr_t bwr;
                assign ram_we[b] = pk_wr.en && (tgt == 1'(b));
                assign bwr       = '{en: ram_we[b], idx: pk_wr.idx, data: pk_wr.data};
                rxpp_buf_ram #(.BUF_WORDS(BUF_WORDS)) u_ram (
                    .clk    (clk),
                    .wr     (bwr),
                    .rd_idx (aidx),
                    .rd_word(ram_rd[b])
                );
            end else begin : g_off
                assign ram_we[b] = 1'b0;
                assign ram_rd[b] = 32'd0;
            end
        end
    endgenerate

    // Select the word a bus read returns
    always_comb begin
        rd_next = 32'd0;
        if (in_rx && bsel_ok) begin
            if (is_stat) begin
                rd_next[DONE_BIT] = done_vec[bsel];
                rd_next[IE_BIT]   = ie_vec[bsel];
            end else begin
                rd_next = ram_rd[bsel];
            end
        end
    end

    // Register read data one cycle after the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)         bus_rdata <= 32'd0;
        else if (bus_rd_en) bus_rdata <= rd_next;
    end
endmodule

// File: rtl/rxpp_checker.sv
// Assertion checker for rx_pingpong_ctrl, attached through bind.
// Assumes well-formed frames and no status write in a completion cycle.
module rxpp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_irq,
    input logic       glb_irq_en,
    input logic       ptr,
    input logic [1:0] done_vec,
    input logic [1:0] ram_we,
    input logic [1:0] stat_wr
);
    // R1: reset leaves nothing pending and no interrupt
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!rx_irq && done_vec == 2'b00));

    // R5: storage never written while its buffer is pending
    assert_no_overwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we & done_vec) == 2'b00);

    // R3: done holds unless software writes that status word
    assert_done_sticky0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_vec[0] && !stat_wr[0]) |=> done_vec[0]);
    assert_done_sticky1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_vec[1] && !stat_wr[1]) |=> done_vec[1]);

    // R4: the order advances only with exactly one completion
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr) |-> ($countones(done_vec & ~$past(done_vec)) == 1));

    // R7: interrupt needs the global enable and a fresh completion
    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> $past(glb_irq_en));
    assert_irq_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> ((done_vec & ~$past(done_vec)) != 2'b00));
endmodule

bind rx_pingpong_ctrl rxpp_checker u_rxpp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_irq    (rx_irq),
    .glb_irq_en(glb_irq_en),
    .ptr       (ptr),
    .done_vec  (done_vec),
    .ram_we    (ram_we),
    .stat_wr   (stat_wr)
);

// File: tb/test_rx_pingpong_ctrl.sv
// Bench: length sweep across a small dual-buffer build, occupancy and drop
// cases, and a single-buffer build. Expected words come from arithmetic.
module test_rx_pingpong_ctrl;
    localparam int W      = 8;
    localparam int MAXB   = W * 4;
    localparam int PING_S = 13'h17FC;
    localparam int PONG_S = 13'h1FFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_last = 1'b0, glb = 1'b0;
    logic [7:0]  rx_data = 8'd0;
    logic [12:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic        irq_a, irq_b;
    int          sel = 0;
    int          n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    rx_pingpong_ctrl #(.DUAL_BUF(1'b1), .BUF_WORDS(W)) i_rx_pingpong_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid && sel == 0), .rx_data(rx_data),
        .rx_last(rx_last), .glb_irq_en(glb), .bus_addr(bus_addr),
        .bus_wr_en(bus_wr && sel == 0), .bus_wdata(bus_wdata),
        .bus_rd_en(bus_rd && sel == 0), .bus_rdata(rdata_a), .rx_irq(irq_a));

    rx_pingpong_ctrl #(.DUAL_BUF(1'b0), .BUF_WORDS(W)) i_single (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid && sel == 1), .rx_data(rx_data),
        .rx_last(rx_last), .glb_irq_en(glb), .bus_addr(bus_addr),
        .bus_wr_en(bus_wr && sel == 1), .bus_wdata(bus_wdata),
        .bus_rd_en(bus_rd && sel == 1), .bus_rdata(rdata_b), .rx_irq(irq_b));

    function automatic logic [7:0] byte_of(int seed, int i);
        return 8'((seed * 37 + i * 11 + 5) & 255);
    endfunction

    function automatic logic [31:0] exp_word(int seed, int len, int w);
        int n = (len < MAXB) ? len : MAXB;
        logic [31:0] v = '0;
        for (int l = 0; l < 4; l++)
            if (w * 4 + l < n) v[8*l +: 8] = byte_of(seed, w * 4 + l);
        return v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_frame(int len, int seed, output logic irq_seen);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = byte_of(seed, i);
            rx_last  = (i == len - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
        irq_seen = (sel == 0) ? irq_a : irq_b;
    endtask

    task automatic bus_write(int addr, logic [31:0] d);
        @(negedge clk);
        bus_addr = 13'(addr); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(int addr, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 13'(addr); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = (sel == 0) ? rdata_a : rdata_b;
    endtask

    task automatic check_frame(string req, int bufi, int len, int seed);
        logic [31:0] d;
        int n = (len < MAXB) ? len : MAXB;
        for (int w = 0; w < (n + 3) / 4; w++) begin
            bus_read(32'h1000 + bufi * 32'h800 + 4 * w, d);
            check(req, d, exp_word(seed, len, w));
        end
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        irq;
        int          nxt;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(PING_S, d); check("R1 ping status", d, 0);
        bus_read(PONG_S, d); check("R1 pong status", d, 0);
        check("R1 irq", 32'(irq_a), 0);

        // R6: enable write and no software set of done
        bus_write(PING_S, 32'h8);
        bus_read(PING_S, d); check("R6 ie write", d, 32'h8);
        bus_write(PONG_S, 32'h1);
        bus_read(PONG_S, d); check("R6 no sw set", d, 0);

        // R2 R3 R4 R7 R8: sweep all lengths, released after each frame
        nxt = 0;
        for (int len = 1; len <= MAXB + 3; len++) begin
            glb = (len % 3 != 0);
            send_frame(len, len, irq);
            check("R7 irq gate", 32'(irq), 32'((nxt == 0) && glb));
            bus_read(nxt ? PONG_S : PING_S, d);
            check("R3 done set", d, nxt ? 32'h1 : 32'h9);
            bus_read(nxt ? PING_S : PONG_S, d);
            check("R4 other idle", d, nxt ? 32'h8 : 32'h0);
            check_frame(len > MAXB ? "R8 truncated data" : "R2 packed data", nxt, len, len);
            if (len > MAXB) begin
                bus_read(32'h1000 + nxt * 32'h800 + 4 * W, d);
                check("R8 beyond reads 0", d, 0);
            end
            bus_write(nxt ? PONG_S : PING_S, nxt ? 32'h0 : 32'h8);
            if (len == 1) begin
                bus_read(PING_S, d); check("R6 release", d, 32'h8);
            end
            nxt ^= 1;
        end

        // R5: both full, third frame dropped
        glb = 1'b1;
        send_frame(6, 100, irq);
        send_frame(9, 101, irq);
        send_frame(5, 102, irq);
        check("R5 drop no irq", 32'(irq), 0);
        bus_read(nxt ? PONG_S : PING_S, d); check("R5 status kept", d, nxt ? 32'h1 : 32'h9);
        check_frame("R5 contents kept", nxt, 6, 100);
        check_frame("R5 contents kept", nxt ^ 1, 9, 101);
        // R5: other buffer free but pointer waits on the pending one
        bus_write(nxt ? PING_S : PONG_S, nxt ? 32'h8 : 32'h0);
        send_frame(4, 103, irq);
        bus_read(nxt ? PING_S : PONG_S, d); check("R5 pointer kept", d, nxt ? 32'h8 : 32'h0);
        bus_write(nxt ? PONG_S : PING_S, nxt ? 32'h0 : 32'h8);
        send_frame(7, 104, irq);
        bus_read(nxt ? PONG_S : PING_S, d); check("R5 lands after release", d, nxt ? 32'h1 : 32'h9);
        check_frame("R5 new data", nxt, 7, 104);

        // R9: single-buffer build
        sel = 1;
        bus_write(PING_S, 32'h8);
        for (int k = 0; k < 4; k++) begin
            send_frame(3 + 5 * k, 200 + k, irq);
            check("R9 irq", 32'(irq), 1);
            bus_read(PING_S, d); check("R9 ping done", d, 32'h9);
            bus_read(PONG_S, d); check("R9 pong status 0", d, 0);
            bus_read(32'h1800, d); check("R9 pong data 0", d, 0);
            check_frame("R9 ping data", 0, 3 + 5 * k, 200 + k);
            bus_write(PING_S, 32'h8);
        end
        send_frame(5, 210, irq);
        send_frame(6, 211, irq);
        check("R9 drop no irq", 32'(irq), 0);
        check_frame("R9 kept first", 0, 5, 210);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule